// File: doc/BRIEF.md
# Signed Integer Format Converter

This block re-encodes an integer from one signed number format into another. Four formats are supported: two's complement, one's complement, sign-magnitude and offset binary with a configurable bias. Two 2-bit selects pick the source and the destination format, so every one of the sixteen pairs is available on any cycle. Internally the input is first decoded into a two's-complement value a few bits wider than either side. That value is then encoded into the destination format. Because the intermediate value is signed, a narrow two's-complement input that is written out to a wider word is sign-extended.

The destination formats do not all cover the same range. A value that does not fit is clamped to the nearest extreme the destination can hold, and an overflow flag is raised. The block also reports whether the input was one of the two redundant negative-zero patterns. The result and both flags are registered, so they appear one clock after the inputs.

Top module: `intfmt_convert`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_val`, `ovf` and `neg_zero` become zero on that edge.
- R2: Outputs change only on a rising clock edge, and they reflect the inputs sampled at that edge. The latency is one cycle.
- R3: Format codes on `src_fmt` and `dst_fmt` are 00 = two's complement, 01 = one's complement, 10 = sign-magnitude and 11 = offset binary. In offset binary the stored code equals value + BIAS, where the bias defaults to 2^(width-1). An input is decoded to its value as follows:
  - in sign-magnitude, the top bit is the sign and the other bits are the magnitude;
  - in one's complement, a negative value is the bitwise inverse of its magnitude;
  - in two's complement, the top bit has weight -2^(width-1).
- R4: The sign-magnitude pattern 1 followed by all zeros and the one's-complement pattern of all ones both decode as zero. `neg_zero` is 1 only when the input is one of these patterns and `src_fmt` selects the matching format.
- R5: A representable value is encoded exactly in the destination format. Sign-magnitude and one's complement hold ±(2^(OUT_W-1)-1). Two's complement holds -2^(OUT_W-1) to 2^(OUT_W-1)-1. Offset binary holds -BIAS to 2^OUT_W-1-BIAS.
- R6: When the destination is sign-magnitude or one's complement, a zero result is always emitted as all zeros.
- R7: A value outside the destination range sets `ovf`, and `out_val` is clamped to the nearest representable extreme. For example, two's-complement -2^(OUT_W-1) becomes -(2^(OUT_W-1)-1) in sign-magnitude or one's complement.
- R8: When OUT_W exceeds IN_W, a two's-complement to two's-complement conversion copies the input's top bit into every added upper bit. For example, 4-bit 1110 becomes 8-bit 11111110.
- R9: `ovf` is 0 whenever the decoded value lies within the destination range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_fmt | input | 2 | Format of `in_val` |
| dst_fmt | input | 2 | Format wanted on `out_val` |
| in_val | input | IN_W | Encoded input integer |
| out_val | output | OUT_W | Re-encoded integer, registered |
| ovf | output | 1 | Value did not fit and was clamped, registered |
| neg_zero | output | 1 | Input was a negative-zero pattern, registered |

## Verification
All state in the block is the output register, so a decode or encode fault is visible as a wrong `out_val` or flag exactly one cycle after the offending input. Such faults include a bias applied with the wrong sign, a missing end correction in one's complement, a clamp bound that is off by one, and a negative zero leaking out. The bench therefore applies every 4-bit input under every format pair, both to an equal-width instance and to a widening instance. Each cycle it compares the registered result against an integer model. The asymmetric endpoints of the ranges and the two negative-zero codes are therefore always covered.

// File: rtl/intfmt_pkg.sv
package intfmt_pkg;

  typedef enum logic [1:0] {
    FMT_TWOS = 2'b00,
    FMT_ONES = 2'b01,
    FMT_SMAG = 2'b10,
    FMT_OFFS = 2'b11
  } fmt_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/intfmt_decode.sv
module intfmt_decode
  import intfmt_pkg::*;
#(
  parameter int IN_W    = 4,
  parameter int BIAS_IN = 2 ** (IN_W - 1),
  parameter int CW      = IN_W + 2
) (
  input  fmt_e                 src,
  input  logic [IN_W-1:0]      code,
  output logic signed [CW-1:0] value,
  output logic                 is_neg_zero
);

  localparam logic signed [CW-1:0] BIAS_C = CW'(BIAS_IN);
  localparam logic [IN_W-1:0]      SM_NZ  = {1'b1, {(IN_W-1){1'b0}}};

  logic                 top_bit;
  logic signed [CW-1:0] sext;
  logic signed [CW-1:0] zext;
  logic signed [CW-1:0] mag;

  always_comb begin
    top_bit = code[IN_W-1];
    sext    = CW'($signed(code));
    zext    = CW'(code);
    mag     = CW'(code[IN_W-2:0]);
    unique case (src)
      FMT_TWOS: value = sext;
      FMT_ONES: value = sext + CW'(top_bit);
      FMT_SMAG: value = top_bit ? -mag : mag;
      default:  value = zext - BIAS_C;
    endcase
    is_neg_zero = ((src == FMT_SMAG) && (code == SM_NZ)) ||
                  ((src == FMT_ONES) && (&code));
  end

  // R4: a flagged negative zero must decode to the value zero
  always_comb begin
    if (is_neg_zero) begin
      AST_NZ_IS_ZERO: assert (value == '0); // R4
    end
  end

endmodule

// File: rtl/intfmt_encode.sv
module intfmt_encode
  import intfmt_pkg::*;
#(
  parameter int OUT_W    = 4,
  parameter int BIAS_OUT = 2 ** (OUT_W - 1),
  parameter int CW       = OUT_W + 2
) (
  input  fmt_e                 dst,
  input  logic signed [CW-1:0] value,
  output logic [OUT_W-1:0]     code,
  output logic                 over
);

  localparam int HALF = 2 ** (OUT_W - 1);
  localparam int FULL = 2 ** OUT_W;

  localparam logic signed [CW-1:0] TC_LO  = CW'(-HALF);
  localparam logic signed [CW-1:0] TC_HI  = CW'(HALF - 1);
  localparam logic signed [CW-1:0] SYM_LO = CW'(1 - HALF);
  localparam logic signed [CW-1:0] SYM_HI = CW'(HALF - 1);
  localparam logic signed [CW-1:0] OF_LO  = CW'(-BIAS_OUT);
  localparam logic signed [CW-1:0] OF_HI  = CW'(FULL - 1 - BIAS_OUT);
  localparam logic signed [CW-1:0] BIAS_C = CW'(BIAS_OUT);

  logic signed [CW-1:0] lo;
  logic signed [CW-1:0] hi;
  logic signed [CW-1:0] clamped;
  logic                 neg;

  always_comb begin
    unique case (dst)
      FMT_TWOS: begin lo = TC_LO;  hi = TC_HI;  end
      FMT_OFFS: begin lo = OF_LO;  hi = OF_HI;  end
      default:  begin lo = SYM_LO; hi = SYM_HI; end
    endcase
    over = (value < lo) || (value > hi);
    if (value < lo)      clamped = lo;
    else if (value > hi) clamped = hi;
    else                 clamped = value;
    neg = clamped[CW-1];
    unique case (dst)
      FMT_TWOS: code = OUT_W'(clamped);
      FMT_ONES: code = OUT_W'(clamped - CW'(neg));
      FMT_SMAG: code = {neg, (OUT_W-1)'(neg ? -clamped : clamped)};
      default:  code = OUT_W'(clamped + BIAS_C);
    endcase
  end

  // R6: sign-magnitude and one's complement never produce a negative zero
  always_comb begin
    if (dst == FMT_SMAG) begin
      AST_SM_POS_ZERO: assert (code != {1'b1, {(OUT_W-1){1'b0}}}); // R6
    end
    if (dst == FMT_ONES) begin
      AST_OC_POS_ZERO: assert (code != {OUT_W{1'b1}}); // R6
    end
  end

endmodule

// File: rtl/intfmt_convert.sv
module intfmt_convert
  import intfmt_pkg::*;
#(
  parameter int IN_W     = 4,
  parameter int OUT_W    = 4,
  parameter int BIAS_IN  = 2 ** (IN_W - 1),
  parameter int BIAS_OUT = 2 ** (OUT_W - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_fmt,
  input  logic [1:0]       dst_fmt,
  input  logic [IN_W-1:0]  in_val,
  output logic [OUT_W-1:0] out_val,
  output logic             ovf,
  output logic             neg_zero
);

  localparam int CW = max_int(IN_W, OUT_W) + 2;

  logic signed [CW-1:0] canon;
  logic                 nz_comb;
  logic [OUT_W-1:0]     enc_comb;
  logic                 ovf_comb;

  intfmt_decode #(.IN_W(IN_W), .BIAS_IN(BIAS_IN), .CW(CW)) u_dec (
    .src         (fmt_e'(src_fmt)),
    .code        (in_val),
    .value       (canon),
    .is_neg_zero (nz_comb)
  );

  intfmt_encode #(.OUT_W(OUT_W), .BIAS_OUT(BIAS_OUT), .CW(CW)) u_enc (
    .dst   (fmt_e'(dst_fmt)),
    .value (canon),
    .code  (enc_comb),
    .over  (ovf_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_val  <= '0;
      ovf      <= 1'b0;
      neg_zero <= 1'b0;
    end else begin
      out_val  <= enc_comb;
      ovf      <= ovf_comb;
      neg_zero <= nz_comb;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (out_val == '0 && !ovf && !neg_zero)); // R1

  AST_NZ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && neg_zero) |->
      ($past(src_fmt) == FMT_SMAG || $past(src_fmt) == FMT_ONES)); // R4

  AST_SM_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ovf && $past(dst_fmt) == FMT_SMAG) |->
      (&out_val[OUT_W-2:0])); // R7

  AST_OC_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ovf && $past(dst_fmt) == FMT_ONES) |->
      (out_val[OUT_W-1] != out_val[OUT_W-2])); // R7

  AST_TWOS_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && OUT_W >= IN_W && $past(src_fmt) == FMT_TWOS &&
     $past(dst_fmt) == FMT_TWOS) |-> !ovf); // R9

  generate
    if (OUT_W >= IN_W) begin : g_widen
      AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(src_fmt) == FMT_TWOS &&
         $past(dst_fmt) == FMT_TWOS) |->
          (out_val == OUT_W'($signed($past(in_val))))); // R8
    end
  endgenerate

endmodule

// File: tb/tb_intfmt_convert.sv
module tb_intfmt_convert;

  localparam int N  = 4;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    src_fmt = 2'b00;
  logic [1:0]    dst_fmt = 2'b00;
  logic [N-1:0]  in_val = '0;
  logic [N-1:0]  out_n;
  logic          ovf_n, nz_n;
  logic [WW-1:0] out_w;
  logic          ovf_w, nz_w;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intfmt_convert #(.IN_W(N), .OUT_W(N)) dut (
    .clk(clk), .rst(rst), .src_fmt(src_fmt), .dst_fmt(dst_fmt),
    .in_val(in_val), .out_val(out_n), .ovf(ovf_n), .neg_zero(nz_n)
  );

  intfmt_convert #(.IN_W(N), .OUT_W(WW)) dut_w (
    .clk(clk), .rst(rst), .src_fmt(src_fmt), .dst_fmt(dst_fmt),
    .in_val(in_val), .out_val(out_w), .ovf(ovf_w), .neg_zero(nz_w)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d (src=%0d dst=%0d in=%0d)",
               tag, what, got, exp, src_fmt, dst_fmt, in_val);
    end
  endtask

  function automatic int ref_decode(input int x, input int f, input int w, input int bias);
    int half = 1 << (w - 1);
    int mask = (1 << w) - 1;
    case (f)
      0: return (x >= half) ? x - (1 << w) : x;
      1: return (x >= half) ? -((~x) & mask) : x;
      2: return (x >= half) ? -(x & (half - 1)) : x;
      default: return x - bias;
    endcase
  endfunction

  function automatic int ref_lo(input int f, input int w, input int bias);
    int half = 1 << (w - 1);
    case (f)
      0: return -half;
      3: return -bias;
      default: return 1 - half;
    endcase
  endfunction

  function automatic int ref_hi(input int f, input int w, input int bias);
    int half = 1 << (w - 1);
    if (f == 3) return (1 << w) - 1 - bias;
    return half - 1;
  endfunction

  function automatic int ref_encode(input int v, input int f, input int w, input int bias);
    int half = 1 << (w - 1);
    int mask = (1 << w) - 1;
    case (f)
      0: return v & mask;
      1: return (v < 0) ? ((~(-v)) & mask) : v;
      2: return (v < 0) ? (half | (-v)) : v;
      default: return v + bias;
    endcase
  endfunction

  task automatic check_width(input int w, input int got_out, input int got_ovf,
                             input int got_nz);
    int x = int'(in_val);
    int s = int'(src_fmt);
    int d = int'(dst_fmt);
    int v = ref_decode(x, s, N, 1 << (N - 1));
    int lo = ref_lo(d, w, 1 << (w - 1));
    int hi = ref_hi(d, w, 1 << (w - 1));
    int c = (v < lo) ? lo : ((v > hi) ? hi : v);
    int exp_ovf = (v < lo || v > hi) ? 1 : 0;
    int exp_out = ref_encode(c, d, w, 1 << (w - 1));
    int exp_nz = ((s == 2 && x == (1 << (N - 1))) || (s == 1 && x == (1 << N) - 1)) ? 1 : 0;
    string otag;
    if (exp_ovf != 0)                         otag = "R7";
    else if (s == 0 && d == 0 && w > N)       otag = "R8";
    else if (c == 0 && (d == 1 || d == 2))    otag = "R6";
    else                                      otag = "R5";
    chk(otag, (w > N) ? "wide out" : "out", got_out, exp_out);
    chk((exp_ovf != 0) ? "R7" : "R9", "ovf", got_ovf, exp_ovf);
    chk((exp_nz != 0) ? "R4" : "R3", "neg_zero", got_nz, exp_nz);
  endtask

  initial begin
    in_val  = 4'b1001;
    src_fmt = 2'b10;
    dst_fmt = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1", "out after reset", int'(out_n), 0);
    chk("R1", "ovf after reset", int'(ovf_n), 0);
    chk("R1", "neg_zero after reset", int'(nz_w), 0);
    rst = 1'b0;
    // two's complement 1110 (-2) into sign-magnitude: 1010
    src_fmt = 2'b00;
    dst_fmt = 2'b10;
    in_val  = 4'b1110;
    #1;
    chk("R2", "out before edge", int'(out_n), 0);
    @(negedge clk);
    chk("R2", "out after one edge", int'(out_n), 10);
    // negative zero of one's complement into offset binary: 1000
    src_fmt = 2'b01;
    dst_fmt = 2'b11;
    in_val  = 4'b1111;
    @(negedge clk);
    chk("R4", "ones negzero to offset", int'(out_n), 8);
    chk("R4", "ones negzero flag", int'(nz_n), 1);
    // -8 two's complement into one's complement saturates to 1000 (-7)
    src_fmt = 2'b00;
    dst_fmt = 2'b01;
    in_val  = 4'b1000;
    @(negedge clk);
    chk("R7", "ones saturate", int'(out_n), 8);
    chk("R7", "ones saturate ovf", int'(ovf_n), 1);
    // sign extension 1110 -> 11111110
    dst_fmt = 2'b00;
    in_val  = 4'b1110;
    @(negedge clk);
    chk("R8", "sign extend", int'(out_w), 254);
    // exhaustive sweep, compared every clock
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int x = 0; x < (1 << N); x++) begin
          src_fmt = 2'(s);
          dst_fmt = 2'(d);
          in_val  = N'(x);
          @(negedge clk);
          check_width(N, int'(out_n), int'(ovf_n), int'(nz_n));
          check_width(WW, int'(out_w), int'(ovf_w), int'(nz_w));
        end
      end
    end
    // reset in mid-run clears outputs again
    src_fmt = 2'b10;
    dst_fmt = 2'b00;
    in_val  = 4'b1111;
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "out after late reset", int'(out_n), 0);
    chk("R1", "wide out after late reset", int'(out_w), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule